// File: doc/BRIEF.md
# Processor Status and Trap Controller

This block owns a processor's status word and decides, every cycle, whether the core must enter its trap handler. It takes eight level interrupt lines, software writes to three control targets (the status word, an inter-processor interrupt latch and a host interrupt latch), and a synchronous trap request that carries a cause code. It presents the status word with its hardware-owned pending field, a registered program counter, a combinational next program counter, a cause register and a trap-taken flag.

Trap entry is a single atomic update. In one clock edge, the block raises supervisor mode, saves the old supervisor bit, clears trap enable, loads the cause and redirects the program counter to a fixed handler address. When several interrupts are eligible in the same cycle, the controller selects the lowest-numbered one. Status bits for features that the configuration leaves out always read as zero.

Top module: `psr_trap_ctrl`

## Requirements
- R1: After reset, `pc_o` is 0x2000 and `cause_o` is 0. `status_o` is 0x00FF00A0: supervisor (bit 5) and 64-bit supervisor (bit 7) are set, the mask field (bits 23:16) is all ones, and trap enable (bit 0) and translation enable (bit 8) are clear. `trap_taken_o` is low.
- R2: A status write (`wr_sel_i`=0) replaces bits 8:0 and 23:16 from `wr_data_i` at the next edge. Bits 15:9 always read zero. The pending field (bits 31:24) is not affected by the write.
- R3: `trap_taken_o` rises for an interrupt only when trap enable (bit 0) is set and some pending bit i (bit 24+i) has its mask bit i (bit 16+i) set.
- R4: Among the eligible interrupts, the lowest index is taken.
- R5: For an interrupt, `cause_o` has bit 63 set and the interrupt index in bits 2:0. For a synchronous trap, bit 63 is clear and `trap_code_i` is in bits 4:0. An eligible interrupt wins over a trap request made in the same cycle.
- R6: On trap entry, supervisor (bit 5) becomes 1, trap enable (bit 0) becomes 0, and previous-supervisor (bit 4) takes the old value of bit 5. All other fields keep their values.
- R7: While a trap is taken, `next_pc_o` is the handler address 0x100 in the same cycle. Otherwise it is `seq_pc_i` when `seq_valid_i` is high, or else `pc_o`. `pc_o` takes `next_pc_o` at each edge.
- R8: A write with `wr_sel_i`=1 sets pending bit 5 to `wr_data_i[0]`. A write with `wr_sel_i`=2 sets pending bit 6 when the data is nonzero and clears it when the data is zero. `irq_i[5]` and `irq_i[6]` are ignored. Every other pending bit i holds `irq_i[i]` as sampled at the previous edge.
- R9: In the default configuration, floating-point enable (bit 1) and vector enable (bit 2) always read zero. Bits 3, 6 and 7 are writable.
- R10: A status write made in a cycle where a trap is taken is dropped. The trap-entry update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control write strobe |
| wr_sel_i | input | 2 | Write target: 0 status, 1 IPI latch, 2 host latch |
| wr_data_i | input | 32 | Write data |
| irq_i | input | 8 | Level interrupt request lines |
| trap_req_i | input | 1 | Synchronous trap request |
| trap_code_i | input | 5 | Synchronous trap cause code |
| seq_valid_i | input | 1 | Sequential program counter update valid |
| seq_pc_i | input | 32 | Sequential next program counter |
| status_o | output | 32 | Status word including pending field |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Program counter for the next cycle |
| cause_o | output | 64 | Cause of the last trap |
| trap_taken_o | output | 1 | A trap or interrupt is accepted this cycle |

## Verification
A wrong mask, enable or pending bit shows up at `trap_taken_o` and `next_pc_o` in the cycle it becomes relevant. A pending bit appears in `status_o` one edge after its line or latch write. Faults in trap entry, such as a lost previous-supervisor bit, a trap enable left set, or a wrong index or cause kind, appear in `status_o` and `cause_o` at the edge right after `trap_taken_o`. A dropped or misfiltered write shows in the status word at the following edge. For these reasons, a reference model compares every output at every cycle, rather than only at the end of a sequence.

// File: rtl/psr_trap_pkg.sv
package psr_trap_pkg;
  // status word geometry
  localparam int ST_W     = 32;
  localparam int SW_W     = 24;   // software-owned low part
  localparam int N_IRQ    = 8;
  localparam int IRQ_IDX_W = $clog2(N_IRQ);
  localparam int MASK_LSB = 16;
  localparam int PEND_LSB = 24;

  // single-bit fields
  localparam int B_ET  = 0;
  localparam int B_EF  = 1;
  localparam int B_EV  = 2;
  localparam int B_EC  = 3;
  localparam int B_PS  = 4;
  localparam int B_S   = 5;
  localparam int B_U64 = 6;
  localparam int B_S64 = 7;
  localparam int B_VM  = 8;

  // bits of the low part that a write may set
  localparam logic [SW_W-1:0] SW_WR_MASK = 24'hFF01FF;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_IPI    = 2'd1,
    SEL_HOST   = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/psr_pending.sv
module psr_pending
  import psr_trap_pkg::*;
#(
  parameter int IPI_LINE  = 5,
  parameter int HOST_LINE = 6
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             ipi_we_i,
  input  logic             ipi_val_i,
  input  logic             host_we_i,
  input  logic             host_val_i,
  output logic [N_IRQ-1:0] pend_o
);
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] pend_d;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_bit
    if (g == IPI_LINE) begin : g_ipi
      assign pend_d[g] = ipi_we_i ? ipi_val_i : pend_q[g];
    end else if (g == HOST_LINE) begin : g_host
      assign pend_d[g] = host_we_i ? host_val_i : pend_q[g];
    end else begin : g_line
      assign pend_d[g] = irq_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pend_q <= '0;
    else          pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R8
  ipi_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ipi_we_i |=> pend_o[IPI_LINE] == $past(ipi_val_i));

  // R8
  host_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !host_we_i |=> $stable(pend_o[HOST_LINE]));
endmodule

// File: rtl/psr_irq_pick.sv
module psr_irq_pick
  import psr_trap_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic [N_IRQ-1:0]     pend_i,
  input  logic [N_IRQ-1:0]     mask_i,
  input  logic                 et_i,
  output logic                 take_o,
  output logic [IRQ_IDX_W-1:0] idx_o
);
  logic [N_IRQ-1:0] elig;
  logic [N_IRQ-1:0] grant;

  always_comb begin
    elig  = pend_i & mask_i & {N_IRQ{et_i}};
    idx_o = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = i[IRQ_IDX_W-1:0];
    end
  end

  // isolate lowest set bit arithmetically, used to cross-check the scan
  assign grant  = elig & (~elig + 1'b1);
  assign take_o = |elig;

  // R4
  pick_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(grant) && (take_o == (grant != '0)));

  // R4
  pick_match_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    take_o |-> grant[idx_o]);
endmodule

// File: rtl/psr_state.sv
module psr_state
  import psr_trap_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              CAUSE_W  = 64,
  parameter int              CODE_W   = 5,
  parameter logic [PC_W-1:0] RESET_PC = 32'h2000,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h100,
  parameter bit              HAS_RV64 = 1'b1,
  parameter bit              HAS_FPU  = 1'b0,
  parameter bit              HAS_RVC  = 1'b1,
  parameter bit              HAS_VEC  = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 st_we_i,
  input  logic [SW_W-1:0]      st_data_i,
  input  logic                 take_irq_i,
  input  logic [IRQ_IDX_W-1:0] irq_idx_i,
  input  logic                 trap_req_i,
  input  logic [CODE_W-1:0]    trap_code_i,
  input  logic                 seq_valid_i,
  input  logic [PC_W-1:0]      seq_pc_i,
  output logic [SW_W-1:0]      sw_o,
  output logic [PC_W-1:0]      pc_o,
  output logic [PC_W-1:0]      next_pc_o,
  output logic [CAUSE_W-1:0]   cause_o,
  output logic                 taken_o
);
  localparam logic [SW_W-1:0] FEAT_OFF =
      (HAS_RV64 ? 24'h0 : (24'h1 << B_U64) | (24'h1 << B_S64))
    | (HAS_FPU  ? 24'h0 : (24'h1 << B_EF))
    | (HAS_RVC  ? 24'h0 : (24'h1 << B_EC))
    | (HAS_VEC  ? 24'h0 : (24'h1 << B_EV));
  localparam logic [SW_W-1:0] SW_RESET =
      ((24'h1 << B_S) | (24'hFF << MASK_LSB) | (HAS_RV64 ? (24'h1 << B_S64) : 24'h0));

  logic [SW_W-1:0]    sw_q, sw_d;
  logic [PC_W-1:0]    pc_q;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               sw_en, pc_en, cause_en, taken;

  assign taken    = take_irq_i | trap_req_i;
  assign sw_en    = taken | st_we_i;
  assign pc_en    = taken | seq_valid_i;
  assign cause_en = taken;

  // next status: trap entry has precedence over a software write
  always_comb begin
    sw_d = sw_q;
    if (taken) begin
      sw_d[B_PS] = sw_q[B_S];
      sw_d[B_S]  = 1'b1;
      sw_d[B_ET] = 1'b0;
    end else if (st_we_i) begin
      sw_d = st_data_i & SW_WR_MASK & ~FEAT_OFF;
    end
  end

  always_comb begin
    cause_d = '0;
    cause_d[CAUSE_W-1] = take_irq_i;
    if (take_irq_i) cause_d[IRQ_IDX_W-1:0] = irq_idx_i;
    else            cause_d[CODE_W-1:0]    = trap_code_i;
  end

  always_comb begin
    if (taken)            next_pc_o = TRAP_VEC;
    else if (seq_valid_i) next_pc_o = seq_pc_i;
    else                  next_pc_o = pc_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   sw_q <= SW_RESET;
    else if (sw_en) sw_q <= sw_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   pc_q <= RESET_PC;
    else if (pc_en) pc_q <= next_pc_o;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)      cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign sw_o    = sw_q;
  assign pc_o    = pc_q;
  assign cause_o = cause_q;
  assign taken_o = taken;

  // R6
  entry_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    taken |=> sw_q[B_S] && !sw_q[B_ET]);

  // R6
  ps_save_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    taken |=> sw_q[B_PS] == $past(sw_q[B_S]));

  // R5
  cause_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    taken |=> cause_q[CAUSE_W-1] == $past(take_irq_i));

  // R10
  write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (taken && st_we_i) |=> $stable(sw_q[SW_W-1:MASK_LSB]));

  // R9
  feat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sw_q & FEAT_OFF) == '0);

  // R7
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    taken |=> pc_q == TRAP_VEC);
endmodule

// File: rtl/psr_trap_ctrl.sv
module psr_trap_ctrl
  import psr_trap_pkg::*;
#(
  parameter int              PC_W      = 32,
  parameter int              CAUSE_W   = 64,
  parameter int              CODE_W    = 5,
  parameter logic [PC_W-1:0] RESET_PC  = 32'h2000,
  parameter logic [PC_W-1:0] TRAP_VEC  = 32'h100,
  parameter int              IPI_LINE  = 5,
  parameter int              HOST_LINE = 6,
  parameter bit              HAS_RV64  = 1'b1,
  parameter bit              HAS_FPU   = 1'b0,
  parameter bit              HAS_RVC   = 1'b1,
  parameter bit              HAS_VEC   = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [ST_W-1:0]    wr_data_i,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic               trap_req_i,
  input  logic [CODE_W-1:0]  trap_code_i,
  input  logic               seq_valid_i,
  input  logic [PC_W-1:0]    seq_pc_i,
  output logic [ST_W-1:0]    status_o,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               trap_taken_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic                 st_we, ipi_we, host_we;
  logic [N_IRQ-1:0]     pend;
  logic [SW_W-1:0]      sw;
  logic                 take_irq;
  logic [IRQ_IDX_W-1:0] irq_idx;

  assign st_we   = wr_en_i && (wr_sel_i == SEL_STATUS);
  assign ipi_we  = wr_en_i && (wr_sel_i == SEL_IPI);
  assign host_we = wr_en_i && (wr_sel_i == SEL_HOST);

  psr_pending #(
    .IPI_LINE  (IPI_LINE),
    .HOST_LINE (HOST_LINE)
  ) u_pend (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .irq_i      (irq_i),
    .ipi_we_i   (ipi_we),
    .ipi_val_i  (wr_data_i[0]),
    .host_we_i  (host_we),
    .host_val_i (|wr_data_i),
    .pend_o     (pend)
  );

  psr_irq_pick u_pick (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .pend_i  (pend),
    .mask_i  (sw[MASK_LSB +: N_IRQ]),
    .et_i    (sw[B_ET]),
    .take_o  (take_irq),
    .idx_o   (irq_idx)
  );

  psr_state #(
    .PC_W     (PC_W),
    .CAUSE_W  (CAUSE_W),
    .CODE_W   (CODE_W),
    .RESET_PC (RESET_PC),
    .TRAP_VEC (TRAP_VEC),
    .HAS_RV64 (HAS_RV64),
    .HAS_FPU  (HAS_FPU),
    .HAS_RVC  (HAS_RVC),
    .HAS_VEC  (HAS_VEC)
  ) u_state (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n),
    .st_we_i     (st_we),
    .st_data_i   (wr_data_i[SW_W-1:0]),
    .take_irq_i  (take_irq),
    .irq_idx_i   (irq_idx),
    .trap_req_i  (trap_req_i),
    .trap_code_i (trap_code_i),
    .seq_valid_i (seq_valid_i),
    .seq_pc_i    (seq_pc_i),
    .sw_o        (sw),
    .pc_o        (pc_o),
    .next_pc_o   (next_pc_o),
    .cause_o     (cause_o),
    .taken_o     (trap_taken_o)
  );

  assign status_o = {pend, sw};

  // R3
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (trap_taken_o && !trap_req_i) |->
      (status_o[B_ET] && ((status_o[PEND_LSB +: N_IRQ] & status_o[MASK_LSB +: N_IRQ]) != '0)));

  // R2
  gap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    status_o[MASK_LSB-1:B_VM+1] == '0);
endmodule

// File: tb/tb_psr_trap_ctrl.sv
module tb_psr_trap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [7:0]  irq;
  logic        trap_req;
  logic [4:0]  trap_code;
  logic        seq_valid;
  logic [31:0] seq_pc;
  logic [31:0] status_o, pc_o, next_pc_o;
  logic [63:0] cause_o;
  logic        trap_taken_o;

  always #2 clk = ~clk;  // 250 MHz

  psr_trap_ctrl dut (
    .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .irq_i(irq), .trap_req_i(trap_req),
    .trap_code_i(trap_code), .seq_valid_i(seq_valid), .seq_pc_i(seq_pc),
    .status_o(status_o), .pc_o(pc_o), .next_pc_o(next_pc_o),
    .cause_o(cause_o), .trap_taken_o(trap_taken_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model state
  logic [23:0] m_sw;
  logic [7:0]  m_pend;
  logic [63:0] m_cause;
  logic [31:0] m_pc;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] filt(logic [31:0] d);
    logic [23:0] f;
    f = d[23:0] & 24'hFF01FF;
    f[1] = 1'b0;
    f[2] = 1'b0;
    return f;
  endfunction

  function automatic logic [2:0] lowest(logic [7:0] v);
    logic [2:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i[2:0];
    return r;
  endfunction

  task automatic idle();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    trap_req = 1'b0; trap_code = '0; seq_valid = 1'b0; seq_pc = '0;
  endtask

  // called right after a falling edge with inputs applied
  task automatic step();
    logic [7:0]  elig;
    logic        tki, tk;
    logic [31:0] npc;
    logic [7:0]  np;
    #1;
    elig = m_pend & m_sw[23:16] & {8{m_sw[0]}};
    tki  = |elig;
    tk   = tki | trap_req;
    npc  = tk ? 32'h100 : (seq_valid ? seq_pc : m_pc);
    chk("R3 trap_taken", {63'd0, trap_taken_o}, {63'd0, tk});
    chk("R7 next_pc", {32'd0, next_pc_o}, {32'd0, npc});
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      if (i == 5)      np[i] = (wr_en && wr_sel == 2'd1) ? wr_data[0] : m_pend[i];
      else if (i == 6) np[i] = (wr_en && wr_sel == 2'd2) ? (wr_data != 0) : m_pend[i];
      else             np[i] = irq[i];
    end
    if (tk) begin
      m_sw[4] = m_sw[5];
      m_sw[5] = 1'b1;
      m_sw[0] = 1'b0;
      m_cause = tki ? {1'b1, 60'd0, lowest(elig)} : {59'd0, trap_code};
    end else if (wr_en && wr_sel == 2'd0) begin
      m_sw = filt(wr_data);
    end
    m_pend = np;
    m_pc   = npc;
    @(negedge clk);
    chk("R2 status", {32'd0, status_o}, {32'd0, m_pend, m_sw});
    chk("R7 pc", {32'd0, pc_o}, {32'd0, m_pc});
    chk("R5 cause", cause_o, m_cause);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    idle();
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED1234);
    idle();
    irq   = '0;
    rst_n = 1'b0;
    m_sw = 24'hFF00A0; m_pend = '0; m_cause = '0; m_pc = 32'h2000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 status reset", {32'd0, status_o}, 64'h00FF00A0);
    chk("R1 pc reset", {32'd0, pc_o}, 64'h2000);
    chk("R1 cause reset", cause_o, 64'd0);
    chk("R1 taken reset", {63'd0, trap_taken_o}, 64'd0);

    // R3: line pending but trap enable clear
    irq = 8'h01;
    step(); step();
    chk("R3 no take with ET clear", {63'd0, trap_taken_o}, 64'd0);

    // R3: enable traps, only mask bit 0, lines 2 and 3 pending
    irq = 8'h0C;
    wr(2'd0, 32'h0001_0021);
    step();
    chk("R3 masked lines ignored", {63'd0, trap_taken_o}, 64'd0);

    // R4: open the whole mask, lowest of 2 and 3 wins
    wr(2'd0, 32'h00FF_0021);
    chk("R4 take with lines 2,3", {63'd0, trap_taken_o}, 64'd1);
    step();
    chk("R5 interrupt cause", cause_o, 64'h8000_0000_0000_0002);
    chk("R6 entry bits S,ET,PS", {61'd0, status_o[5], status_o[4], status_o[0]}, 64'b110);

    // R9: write all ones, unbuilt feature bits stay zero
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R9 feature filter", {40'd0, status_o[23:0]}, 64'hFF01F9);

    // R10: interrupt now eligible, a concurrent status write is dropped
    wr(2'd0, 32'h0000_0000);
    chk("R10 write dropped", {40'd0, status_o[23:0]}, 64'hFF01F8);

    irq = 8'h00;
    wr(2'd0, 32'h0000_0000);

    // R8: software latches, lines 5 and 6 ignored
    irq = 8'h60;
    wr(2'd1, 32'h0000_0001);
    chk("R8 ipi set", {56'd0, status_o[31:24]}, 64'h20);
    irq = 8'h00;
    wr(2'd2, 32'h0000_0010);
    chk("R8 host set", {56'd0, status_o[31:24]}, 64'h60);
    wr(2'd2, 32'h0000_0000);
    chk("R8 host clear", {56'd0, status_o[31:24]}, 64'h20);
    wr(2'd1, 32'h0000_0002);
    chk("R8 ipi clear", {56'd0, status_o[31:24]}, 64'h00);

    // R5/R6: synchronous trap from user mode
    idle();
    trap_req = 1'b1; trap_code = 5'h13;
    step();
    idle();
    chk("R5 trap cause", cause_o, 64'h13);
    chk("R6 trap from user", {62'd0, status_o[5], status_o[4]}, 64'b10);

    // R7: sequential pc
    seq_valid = 1'b1; seq_pc = 32'h4444;
    step();
    idle();
    chk("R7 sequential pc", {32'd0, pc_o}, 64'h4444);
    step();
    chk("R7 pc hold", {32'd0, pc_o}, 64'h4444);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      idle();
      irq = $urandom();
      if ($urandom_range(9) == 0) begin
        wr_en   = 1'b1;
        wr_sel  = $urandom_range(3);
        wr_data = $urandom();
      end
      if ($urandom_range(19) == 0) begin
        trap_req  = 1'b1;
        trap_code = $urandom();
      end
      seq_valid = $urandom_range(1);
      seq_pc    = $urandom();
      step();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule